// File: doc/BRIEF.md
# Dual-Port Memory Access Collision Detector

This block sits beside a true dual-port synchronous memory that has one common clock. It watches the access each port makes in every cycle. A port makes an access when its enable is high at the clock edge. The access carries a direction (read or write) and the port's internal registered word address. When both ports touch the same word within one cycle of each other, and at least one of them writes, the block pulls an active-low collision flag low for one cycle. It does so on the port or ports that lost data integrity. When one port reads and the other writes, only the reader is flagged. When both ports write, both are flagged. Two reads never count as a collision.

The flag latency tells the two timing cases apart. If both accesses land on the same clock edge, both flags fall two edges after that edge. If one port's access lands exactly one edge before the other's, the match is counted at the later (trailing) edge. The trailing port's flag then falls two edges after the match, and the leading port's flag falls three edges after it. Accesses two or more edges apart are not collisions. The address inputs must already be the memory's internal registered addresses, as produced by the address counter logic, and not the raw external bus.

Top module: `dpcol_top`

## Requirements
- R1: With `rst_n` low at a clock edge, both flags are high after that edge. A collision whose pipeline is still in flight when reset is sampled never produces a flag.
- R2: Two enabled reads of the same address, on the same edge or one edge apart, never pull either flag low.
- R3: A read and a write to the same address on the same edge pull low only the reader's flag. The flag is low in the cycle that follows the second clock edge after the access edge.
- R4: Two writes to the same address on the same edge pull both flags low in the cycle that follows the second edge after the access edge.
- R5: Enabled accesses whose addresses differ never pull a flag low.
- R6: An access from a port whose enable is low takes part in no collision, whatever its direction and address.
- R7: When one port's access comes exactly one edge before the other's, to the same address and with at least one write, the match edge is the later access edge. A flagged trailing port goes low after the second edge past the match. A flagged leading port goes low after the third edge past the match. Which port is flagged follows R3 and R4: the reader, or both when both write.
- R8: Accesses to the same address that are two or more edges apart never pull a flag low.
- R9: Each detected collision holds a port's flag low for exactly one cycle.
- R10: When several collisions overlap, each port's flag is low in every cycle that any of them selects for that port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| l_en | input | 1 | Left port enable, sampled at the clock edge |
| l_wr | input | 1 | Left port direction, 1 = write, 0 = read |
| l_addr | input | AW | Left port internal registered word address |
| r_en | input | 1 | Right port enable, sampled at the clock edge |
| r_wr | input | 1 | Right port direction, 1 = write, 0 = read |
| r_addr | input | AW | Right port internal registered word address |
| l_col_n | output | 1 | Left port collision flag, active low |
| r_col_n | output | 1 | Right port collision flag, active low |

## Verification
A wrong bit in the sampled-access registers or in the delay pipeline shows at the ports no later than four edges after the access that loaded it. It appears as a flag pulse on the wrong port, one cycle early or late, held too long, or missing. The bench sweeps every combination of enable and direction on both ports over an eight-word address space, at offsets of zero, one and two edges in both leading orders. It checks both flags in every cycle of each window against a timeline computed from the rules. This exposes any such fault within the trial that provokes it. Directed runs cover reset arriving with a collision in flight, and overlapping collisions that stretch one flag over two cycles.

// File: rtl/dpcol_pkg.sv
// Package: shared constants, types and the flag-selection rule for the
// dual-port collision detector.
// Assumes: exactly two ports, indexed left = 0 and right = 1.
package dpcol_pkg;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_L    = 0;
    localparam int unsigned PORT_R    = 1;

    // Direction encoding on the *_wr inputs.
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    // Per-port detection result for one evaluation cycle.
    //   near : flag with the short latency (same edge, or port trailing)
    //   far  : flag with the long latency (port leading by one edge)
    typedef struct packed {
        logic near;
        logic far;
    } hit_t;

    // A port is flagged when it read, or when both ports wrote.
    function automatic logic port_is_victim(input logic own_wr, input logic other_wr);
        return (own_wr == DIR_READ) || (other_wr == DIR_WRITE);
    endfunction

    // A pair of accesses conflicts only when at least one side writes.
    function automatic logic pair_conflicts(input logic wr_a, input logic wr_b);
        return (wr_a == DIR_WRITE) || (wr_b == DIR_WRITE);
    endfunction

endpackage

// File: rtl/dpcol_sampler.sv
// Module: dpcol_sampler
// Captures one port's access (enable, direction, address) at each edge and
// keeps the access from the edge before, so that same-edge and one-edge-offset
// pairs can both be compared.
// Assumes: addr is the memory's internal registered address; direction and
// address are meaningful only when en is high.
module dpcol_sampler #(
    parameter int unsigned AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic          cur_en,
    output logic          cur_wr,
    output logic [AW-1:0] cur_addr,
    output logic          prv_en,
    output logic          prv_wr,
    output logic [AW-1:0] prv_addr
);

    // Stage 1: the access sampled at the most recent edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_en   <= 1'b0;
            cur_wr   <= 1'b0;
            cur_addr <= '0;
        end else begin
            cur_en   <= en;
            cur_wr   <= wr;
            cur_addr <= addr;
        end
    end

    // Stage 2: the access sampled one edge earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv_en   <= 1'b0;
            prv_wr   <= 1'b0;
            prv_addr <= '0;
        end else begin
            prv_en   <= cur_en;
            prv_wr   <= cur_wr;
            prv_addr <= cur_addr;
        end
    end

endmodule

// File: rtl/dpcol_compare.sv
// Module: dpcol_compare
// Combinational classifier. From both ports' current and previous accesses it
// decides which port is hit, and whether that hit takes the short latency
// (same edge, or the port trails) or the long one (the port leads).
// Assumes: inputs come straight from dpcol_sampler registers.
module dpcol_compare
    import dpcol_pkg::*;
#(
    parameter int unsigned AW = 19
) (
    input  logic          l_cur_en,
    input  logic          l_cur_wr,
    input  logic [AW-1:0] l_cur_addr,
    input  logic          l_prv_en,
    input  logic          l_prv_wr,
    input  logic [AW-1:0] l_prv_addr,
    input  logic          r_cur_en,
    input  logic          r_cur_wr,
    input  logic [AW-1:0] r_cur_addr,
    input  logic          r_prv_en,
    input  logic          r_prv_wr,
    input  logic [AW-1:0] r_prv_addr,
    output hit_t          hit_l,
    output hit_t          hit_r
);

    logic same_edge;    // both ports on the newest edge
    logic l_leads;      // left one edge earlier, right on newest edge
    logic r_leads;      // right one edge earlier, left on newest edge

    // Pair qualification: both enabled, same word, at least one writer.
    always_comb begin
        same_edge = l_cur_en && r_cur_en && (l_cur_addr == r_cur_addr)
                    && pair_conflicts(l_cur_wr, r_cur_wr);
        l_leads   = l_prv_en && r_cur_en && (l_prv_addr == r_cur_addr)
                    && pair_conflicts(l_prv_wr, r_cur_wr);
        r_leads   = r_prv_en && l_cur_en && (r_prv_addr == l_cur_addr)
                    && pair_conflicts(r_prv_wr, l_cur_wr);
    end

    // Victim selection and latency class for each port.
    always_comb begin
        hit_l.near = (same_edge && port_is_victim(l_cur_wr, r_cur_wr))
                   || (r_leads  && port_is_victim(l_cur_wr, r_prv_wr));
        hit_l.far  =  l_leads   && port_is_victim(l_prv_wr, r_cur_wr);
        hit_r.near = (same_edge && port_is_victim(r_cur_wr, l_cur_wr))
                   || (l_leads  && port_is_victim(r_cur_wr, l_prv_wr));
        hit_r.far  =  r_leads   && port_is_victim(r_prv_wr, l_cur_wr);
    end

endmodule

// File: rtl/dpcol_flagpipe.sv
// Module: dpcol_flagpipe
// Per-port delay line. Hits classified one cycle after the match edge are
// delayed so that the active-low flag register falls NEAR_LAT or FAR_LAT edges
// after the match edge, and stays low one cycle per hit.
// Assumes: 2 <= NEAR_LAT < FAR_LAT.
module dpcol_flagpipe
    import dpcol_pkg::*;
#(
    parameter int unsigned NEAR_LAT = 2,
    parameter int unsigned FAR_LAT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  hit_t hit,
    output logic col_n
);

    localparam int unsigned NS = NEAR_LAT - 1;
    localparam int unsigned FS = FAR_LAT - 1;

    logic [NS-1:0] near_sh;
    logic [FS-1:0] far_sh;

    generate
        if (NS == 1) begin : g_near_one
            // Short path: single delay stage.
            always_ff @(posedge clk) begin
                if (!rst_n) near_sh <= '0;
                else        near_sh <= hit.near;
            end
        end else begin : g_near_many
            // Short path: multi-stage shift.
            always_ff @(posedge clk) begin
                if (!rst_n) near_sh <= '0;
                else        near_sh <= {near_sh[NS-2:0], hit.near};
            end
        end

        if (FS == 1) begin : g_far_one
            // Long path: single delay stage.
            always_ff @(posedge clk) begin
                if (!rst_n) far_sh <= '0;
                else        far_sh <= hit.far;
            end
        end else begin : g_far_many
            // Long path: multi-stage shift.
            always_ff @(posedge clk) begin
                if (!rst_n) far_sh <= '0;
                else        far_sh <= {far_sh[FS-2:0], hit.far};
            end
        end
    endgenerate

    // Output register: low whenever either path delivers a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) col_n <= 1'b1;
        else        col_n <= ~(near_sh[NS-1] | far_sh[FS-1]);
    end

endmodule

// File: rtl/dpcol_top.sv
// Module: dpcol_top
// Collision detector for a two-port synchronous memory on one clock. Samples
// each port's access, classifies same-edge and one-edge-offset conflicts, and
// drives one active-low flag per port with the matching latency.
// Assumes: *_addr are internal registered addresses; enables and directions
// are stable around the clock edge; AW >= 1.
module dpcol_top
    import dpcol_pkg::*;
#(
    parameter int unsigned AW       = 19,
    parameter int unsigned NEAR_LAT = 2,
    parameter int unsigned FAR_LAT  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_en,
    input  logic          l_wr,
    input  logic [AW-1:0] l_addr,
    input  logic          r_en,
    input  logic          r_wr,
    input  logic [AW-1:0] r_addr,
    output logic          l_col_n,
    output logic          r_col_n
);

    logic [NUM_PORTS-1:0] in_en;
    logic [NUM_PORTS-1:0] in_wr;
    logic [AW-1:0]        in_addr  [NUM_PORTS];
    logic [NUM_PORTS-1:0] cur_en;
    logic [NUM_PORTS-1:0] cur_wr;
    logic [AW-1:0]        cur_addr [NUM_PORTS];
    logic [NUM_PORTS-1:0] prv_en;
    logic [NUM_PORTS-1:0] prv_wr;
    logic [AW-1:0]        prv_addr [NUM_PORTS];
    hit_t                 hit      [NUM_PORTS];
    logic [NUM_PORTS-1:0] col_n;

    // Gather the port pins into indexed form.
    always_comb begin
        in_en[PORT_L]   = l_en;
        in_wr[PORT_L]   = l_wr;
        in_addr[PORT_L] = l_addr;
        in_en[PORT_R]   = r_en;
        in_wr[PORT_R]   = r_wr;
        in_addr[PORT_R] = r_addr;
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            dpcol_sampler #(
                .AW (AW)
            ) u_sampler (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (in_en[p]),
                .wr       (in_wr[p]),
                .addr     (in_addr[p]),
                .cur_en   (cur_en[p]),
                .cur_wr   (cur_wr[p]),
                .cur_addr (cur_addr[p]),
                .prv_en   (prv_en[p]),
                .prv_wr   (prv_wr[p]),
                .prv_addr (prv_addr[p])
            );

            dpcol_flagpipe #(
                .NEAR_LAT (NEAR_LAT),
                .FAR_LAT  (FAR_LAT)
            ) u_flagpipe (
                .clk   (clk),
                .rst_n (rst_n),
                .hit   (hit[p]),
                .col_n (col_n[p])
            );
        end
    endgenerate

    dpcol_compare #(
        .AW (AW)
    ) u_compare (
        .l_cur_en   (cur_en[PORT_L]),
        .l_cur_wr   (cur_wr[PORT_L]),
        .l_cur_addr (cur_addr[PORT_L]),
        .l_prv_en   (prv_en[PORT_L]),
        .l_prv_wr   (prv_wr[PORT_L]),
        .l_prv_addr (prv_addr[PORT_L]),
        .r_cur_en   (cur_en[PORT_R]),
        .r_cur_wr   (cur_wr[PORT_R]),
        .r_cur_addr (cur_addr[PORT_R]),
        .r_prv_en   (prv_en[PORT_R]),
        .r_prv_wr   (prv_wr[PORT_R]),
        .r_prv_addr (prv_addr[PORT_R]),
        .hit_l      (hit[PORT_L]),
        .hit_r      (hit[PORT_R])
    );

    // Drive the flag pins from the per-port pipelines.
    always_comb begin
        l_col_n = col_n[PORT_L];
        r_col_n = col_n[PORT_R];
    end

endmodule

// File: rtl/dpcol_checker.sv
// Module: dpcol_checker
// Port-level properties of dpcol_top for the default latencies (2 and 3).
// A flag set at edge k+2 is seen by a concurrent property at edge k+3.
module dpcol_checker #(
    parameter int unsigned AW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l_en,
    input logic          l_wr,
    input logic [AW-1:0] l_addr,
    input logic          r_en,
    input logic          r_wr,
    input logic [AW-1:0] r_addr,
    input logic          l_col_n,
    input logic          r_col_n
);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (l_col_n && r_col_n));

    p_read_write_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && r_en && !l_wr && r_wr && (l_addr == r_addr)) |-> ##3 !l_col_n);

    p_read_write_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && r_en && l_wr && !r_wr && (l_addr == r_addr)) |-> ##3 !r_col_n);

    p_write_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && r_en && l_wr && r_wr && (l_addr == r_addr))
        |-> ##3 (!l_col_n && !r_col_n));

    p_left_leads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(l_en) && $past(l_wr) && r_en && r_wr
         && ($past(l_addr) == r_addr))
        |-> ##3 !r_col_n ##1 !l_col_n);

    p_left_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !l_col_n |-> (($past(l_en, 3) || $past(l_en, 5))
                      && ($past(r_en, 3) || $past(r_en, 4))));

    p_right_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !r_col_n |-> (($past(r_en, 3) || $past(r_en, 5))
                      && ($past(l_en, 3) || $past(l_en, 4))));

endmodule

bind dpcol_top dpcol_checker #(
    .AW (AW)
) u_dpcol_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_en    (l_en),
    .l_wr    (l_wr),
    .l_addr  (l_addr),
    .r_en    (r_en),
    .r_wr    (r_wr),
    .r_addr  (r_addr),
    .l_col_n (l_col_n),
    .r_col_n (r_col_n)
);

// File: tb/test_dpcol_top.sv
`timescale 1ns/1ps
module test_dpcol_top;

    localparam int unsigned AW    = 3;
    localparam int unsigned NADDR = 1 << AW;
    localparam int unsigned WIN   = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_en = 1'b0;
    logic          l_wr = 1'b0;
    logic [AW-1:0] l_addr = '0;
    logic          r_en = 1'b0;
    logic          r_wr = 1'b0;
    logic [AW-1:0] r_addr = '0;
    logic          l_col_n;
    logic          r_col_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dpcol_top #(.AW(AW)) i_dpcol_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_en    (l_en),
        .l_wr    (l_wr),
        .l_addr  (l_addr),
        .r_en    (r_en),
        .r_wr    (r_wr),
        .r_addr  (r_addr),
        .l_col_n (l_col_n),
        .r_col_n (r_col_n)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Expected low flag for port "me" at sample c (after edge c), single accesses.
    function automatic bit exp_low(int c, bit en_me, bit wr_me, int a_me, int t_me,
                                   bit en_o, bit wr_o, int a_o, int t_o);
        int d;
        int k;
        int lat;
        if (!en_me || !en_o || a_me != a_o) return 1'b0;       // R5, R6
        d = t_me - t_o;
        if (d > 1 || d < -1) return 1'b0;                       // R8
        if (!wr_me && !wr_o) return 1'b0;                       // R2
        if (!(!wr_me || wr_o)) return 1'b0;                     // R3: writer vs reader
        k   = (t_me > t_o) ? t_me : t_o;
        lat = (d == 0) ? 2 : ((t_me < t_o) ? 3 : 2);            // R7
        return c == k + lat;                                    // R9: one cycle only
    endfunction

    function automatic string tag_of(bit el, bit wl, int al, int tl, bit er, bit wr_, int ar, int tr);
        int d;
        d = tl - tr;
        if (!el || !er) return "R6";
        if (al != ar) return "R5";
        if (d > 1 || d < -1) return "R8";
        if (d != 0) return "R7";
        if (!wl && !wr_) return "R2";
        if (wl && wr_) return "R4";
        return "R3";
    endfunction

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stimulus
        int tl_tab [5] = '{0, 0, 1, 0, 2};
        int tr_tab [5] = '{0, 1, 0, 2, 0};
        repeat (3) @(negedge clk);
        check("R1", "reset l_col_n", l_col_n, 1'b1);
        check("R1", "reset r_col_n", r_col_n, 1'b1);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1: reset sampled while a double write is in flight.
        for (int c = 0; c < WIN; c++) begin
            l_en = (c == 0); l_wr = 1'b1; l_addr = 3'd5;
            r_en = (c == 0); r_wr = 1'b1; r_addr = 3'd5;
            rst_n = (c != 1);
            @(posedge clk);
            @(negedge clk);
            check("R1", "in-flight l", l_col_n, 1'b1);
            check("R1", "in-flight r", r_col_n, 1'b1);
        end
        l_en = 1'b0; r_en = 1'b0; rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10: left writes at edges 0 and 1, right writes at edge 1, same word.
        for (int c = 0; c < WIN; c++) begin
            l_en = (c == 0) || (c == 1); l_wr = 1'b1; l_addr = 3'd2;
            r_en = (c == 1);             r_wr = 1'b1; r_addr = 3'd2;
            @(posedge clk);
            @(negedge clk);
            check("R10", $sformatf("overlap l c=%0d", c), l_col_n, !((c == 3) || (c == 4)));
            check("R10", $sformatf("overlap r c=%0d", c), r_col_n, !(c == 3));
        end
        l_en = 1'b0; r_en = 1'b0;
        repeat (4) @(negedge clk);

        // Sweep: every enable/direction mix, every address pair, five timings.
        for (int oi = 0; oi < 5; oi++) begin
            for (int m = 0; m < 16; m++) begin
                for (int al = 0; al < NADDR; al++) begin
                    for (int ar = 0; ar < NADDR; ar++) begin
                        bit el;
                        bit wl;
                        bit er;
                        bit wrr;
                        string tg;
                        el = m[0]; wl = m[1]; er = m[2]; wrr = m[3];
                        tg = tag_of(el, wl, al, tl_tab[oi], er, wrr, ar, tr_tab[oi]);
                        for (int c = 0; c < WIN; c++) begin
                            bit xl;
                            bit xr;
                            l_en = el && (c == tl_tab[oi]); l_wr = wl;  l_addr = al[AW-1:0];
                            r_en = er && (c == tr_tab[oi]); r_wr = wrr; r_addr = ar[AW-1:0];
                            @(posedge clk);
                            @(negedge clk);
                            xl = exp_low(c, el, wl, al, tl_tab[oi], er, wrr, ar, tr_tab[oi]);
                            xr = exp_low(c, er, wrr, ar, tr_tab[oi], el, wl, al, tl_tab[oi]);
                            check(tg, $sformatf("l t=%0d/%0d m=%0d a=%0d/%0d c=%0d",
                                  tl_tab[oi], tr_tab[oi], m, al, ar, c), l_col_n, !xl);
                            check((tg == "R2" || tg == "R5" || tg == "R6" || tg == "R8") ? tg : "R9",
                                  $sformatf("r t=%0d/%0d m=%0d a=%0d/%0d c=%0d",
                                  tl_tab[oi], tr_tab[oi], m, al, ar, c), r_col_n, !xr);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule